// File: doc/BRIEF.md
# System Management Mode Entry and Resume Sequencer

This block steps a simple processor model into and out of system management mode. When a management interrupt request arrives, it writes a short save record through a single memory port. The record holds the current base address, a formatted I/O trap word, a cleared I/O restart slot and a HALT restart slot. It then raises a vector-fetch request at a fixed distance above the base. While the handler runs, it may edit those slots in memory. A resume command then makes the block read the slots back. It adopts the saved base for the next entry and chooses how execution continues: re-run the trapped I/O instruction, go back into the interrupted HALT, or carry on at the next instruction.

The base is relocatable but must stay aligned to a 32 KiB boundary. If a misaligned base is read back at resume, the block stops in a shutdown state that only reset clears. A request that arrives while a previous one is still being serviced is held and taken as soon as the resume finishes.

Top module: `smm_seq`

## Requirements
- R1: After reset the base register holds 0x30000, `in_smm`, `mem_valid`, `vec_req` and `shutdown` are low, and the first entry therefore uses base 0x30000.
- R2: Entry first writes the current base value to address base+0x7EF8.
- R3: Entry writes the trap word to base+0x7EFC. Its bits 31:16 carry the I/O address, bits 15:2 are zero, bit 1 is the valid-I/O flag and bit 0 is 1 for a read and 0 for a write. When the flag is 0, the address and read/write fields are written as zero.
- R4: Entry writes 0x00000000 to the I/O restart slot at base+0x7F00. It writes the HALT restart slot at base+0x7F04, with bit 0 set to 1 when `cpu_halted` was high with the request and all other bits 0.
- R5: After the four writes, `vec_req` and `entry_done` pulse together for one cycle with `vec_addr` = base+0x8000, and `in_smm` is high from then until the resume completes.
- R6: Each memory access holds `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` steady until `mem_ready` is sampled high, and the block issues at most one access per cycle.
- R7: On resume, when bits 7:0 of the I/O restart slot read 0xFF, `resume_act` is 1 (re-execute the I/O instruction), whatever the HALT slot says.
- R8: Otherwise, let E be the HALT bit written at entry and X be bit 0 read back. E=1 with X=1 gives `resume_act`=2 (return to HALT). E=1 with X=0 and E=0 with X=0 both give 0 (next instruction). E=0 with X=1 gives 0 together with a `halt_err` pulse.
- R9: The value read from base+0x7EF8 at resume becomes the base for every later entry.
- R10: A read-back base with any of bits 14:0 set makes `shutdown` go high and stay high until reset. No `resume_done` is produced, and no later request or resume causes a memory access.
- R11: A request that arrives while an entry or resume is in progress is kept, with its own trap data, and serviced with a full entry right after `resume_done`.
- R12: `resume_done` pulses for one cycle with `resume_act` and `halt_err` valid and `in_smm` low. A resume strobe while not in management mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_req | input | 1 | Management interrupt request, sampled each cycle |
| rsm_req | input | 1 | Resume command strobe |
| cpu_halted | input | 1 | The core was in HALT when the request was raised |
| trap_io_valid | input | 1 | The request trapped a valid I/O instruction |
| trap_io_addr | input | 16 | Trapped I/O address |
| trap_io_read | input | 1 | Trapped access was a read (1) or write (0) |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts or completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| vec_req | output | 1 | Vector-fetch request pulse |
| vec_addr | output | 32 | Vector-fetch address |
| entry_done | output | 1 | Entry sequence complete pulse |
| resume_done | output | 1 | Resume sequence complete pulse |
| resume_act | output | 2 | 0 next instruction, 1 re-execute I/O, 2 return to HALT |
| halt_err | output | 1 | Invalid HALT restart combination flagged with `resume_done` |
| in_smm | output | 1 | Block is inside management mode |
| shutdown | output | 1 | Misaligned base seen; block halted |

## Verification
The hardest cases to reach are those that depend on slot contents the handler changes between entry and resume, and a second request that lands while the first is still being serviced. The bench therefore plays the handler. After each `entry_done` it edits the HALT slot, the I/O slot or the base slot directly in its memory model before strobing resume, covering every HALT combination, a relocation and a misaligned base. It raises a second request inside management mode and expects an automatic second entry carrying the second trap word. It also repeats a full entry and resume with a memory that accepts only every other cycle, to confirm that request signals hold steady.

// File: rtl/smm_pkg.sv
package smm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_W_BASE,
        S_W_TRAP,
        S_W_IO,
        S_W_HALT,
        S_VEC,
        S_SMM,
        S_R_BASE,
        S_R_IO,
        S_R_HALT,
        S_DEC,
        S_SHUT
    } smm_state_e;

    typedef enum logic [1:0] {
        ACT_NEXT = 2'd0,
        ACT_IO   = 2'd1,
        ACT_HALT = 2'd2
    } resume_act_e;

    localparam logic [15:0] OFF_BASE_SLOT = 16'h7EF8;
    localparam logic [15:0] OFF_TRAP_SLOT = 16'h7EFC;
    localparam logic [15:0] OFF_IO_SLOT   = 16'h7F00;
    localparam logic [15:0] OFF_HALT_SLOT = 16'h7F04;
    localparam logic [15:0] OFF_VECTOR    = 16'h8000;
    localparam logic [7:0]  IO_RERUN_CODE = 8'hFF;

endpackage

// File: rtl/smm_trap_fmt.sv
module smm_trap_fmt #(
    parameter int DATA_W = 32,
    parameter int IOA_W  = 16
) (
    input  logic              io_valid,
    input  logic [IOA_W-1:0]  io_addr,
    input  logic              io_read,
    output logic [DATA_W-1:0] word
);
    localparam int RSV_W = DATA_W - IOA_W - 2;

    always_comb begin
        if (io_valid) begin
            word = {io_addr, {RSV_W{1'b0}}, 1'b1, io_read};
        end else begin
            word = '0;
        end
    end
endmodule

// File: rtl/smm_resume_dec.sv
module smm_resume_dec
    import smm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 15
) (
    input  logic [ADDR_W-1:0] new_base,
    input  logic [7:0]        io_slot,
    input  logic              halt_entry,
    input  logic              halt_exit,
    output logic              base_ok,
    output resume_act_e       act,
    output logic              bad_halt
);
    always_comb begin
        base_ok  = (new_base[ALIGN_BITS-1:0] == '0);
        act      = ACT_NEXT;
        bad_halt = 1'b0;
        if (io_slot == IO_RERUN_CODE) begin
            act = ACT_IO;
        end else if (halt_entry && halt_exit) begin
            act = ACT_HALT;
        end else if (!halt_entry && halt_exit) begin
            bad_halt = 1'b1;
        end
    end
endmodule

// File: rtl/smm_seq.sv
module smm_seq
    import smm_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              DATA_W     = 32,
    parameter int              IOA_W      = 16,
    parameter int              ALIGN_BITS = 15,
    parameter logic [31:0]     RESET_BASE = 32'h0003_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smi_req,
    input  logic              rsm_req,
    input  logic              cpu_halted,
    input  logic              trap_io_valid,
    input  logic [IOA_W-1:0]  trap_io_addr,
    input  logic              trap_io_read,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              entry_done,
    output logic              resume_done,
    output logic [1:0]        resume_act,
    output logic              halt_err,
    output logic              in_smm,
    output logic              shutdown
);

    typedef struct packed {
        smm_state_e        state;
        logic [ADDR_W-1:0] base;
        logic              pend;
        logic [DATA_W-1:0] pend_trap;
        logic              pend_halt;
        logic [DATA_W-1:0] cur_trap;
        logic              cur_halt;
        logic [ADDR_W-1:0] rd_base;
        logic [7:0]        rd_io;
        logic              rd_halt;
        logic              done;
        resume_act_e       act;
        logic              err;
    } seq_t;

    seq_t r_q, r_d;

    logic [DATA_W-1:0] fmt_word;
    logic              dec_base_ok;
    resume_act_e       dec_act;
    logic              dec_bad_halt;

    smm_trap_fmt #(
        .DATA_W (DATA_W),
        .IOA_W  (IOA_W)
    ) i_trap_fmt (
        .io_valid (trap_io_valid),
        .io_addr  (trap_io_addr),
        .io_read  (trap_io_read),
        .word     (fmt_word)
    );

    smm_resume_dec #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) i_resume_dec (
        .new_base   (r_q.rd_base),
        .io_slot    (r_q.rd_io),
        .halt_entry (r_q.cur_halt),
        .halt_exit  (r_q.rd_halt),
        .base_ok    (dec_base_ok),
        .act        (dec_act),
        .bad_halt   (dec_bad_halt)
    );

    // next-state logic
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (r_q.pend) begin
                    r_d.pend     = 1'b0;
                    r_d.cur_trap = r_q.pend_trap;
                    r_d.cur_halt = r_q.pend_halt;
                    r_d.state    = S_W_BASE;
                end
            end
            S_W_BASE: if (mem_ready) r_d.state = S_W_TRAP;
            S_W_TRAP: if (mem_ready) r_d.state = S_W_IO;
            S_W_IO:   if (mem_ready) r_d.state = S_W_HALT;
            S_W_HALT: if (mem_ready) r_d.state = S_VEC;
            S_VEC:    r_d.state = S_SMM;
            S_SMM:    if (rsm_req) r_d.state = S_R_BASE;
            S_R_BASE: begin
                if (mem_ready) begin
                    r_d.rd_base = ADDR_W'(mem_rdata);
                    r_d.state   = S_R_IO;
                end
            end
            S_R_IO: begin
                if (mem_ready) begin
                    r_d.rd_io = mem_rdata[7:0];
                    r_d.state = S_R_HALT;
                end
            end
            S_R_HALT: begin
                if (mem_ready) begin
                    r_d.rd_halt = mem_rdata[0];
                    r_d.state   = S_DEC;
                end
            end
            S_DEC: begin
                if (!dec_base_ok) begin
                    r_d.state = S_SHUT;
                end else begin
                    r_d.base  = r_q.rd_base;
                    r_d.act   = dec_act;
                    r_d.err   = dec_bad_halt;
                    r_d.done  = 1'b1;
                    r_d.state = S_IDLE;
                end
            end
            S_SHUT:   r_d.state = S_SHUT;
            default:  r_d.state = S_IDLE;
        endcase
        if (smi_req && r_q.state != S_SHUT) begin
            r_d.pend      = 1'b1;
            r_d.pend_trap = fmt_word;
            r_d.pend_halt = cpu_halted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= S_IDLE;
            r_q.base    <= ADDR_W'(RESET_BASE);
            r_q.act     <= ACT_NEXT;
        end else begin
            r_q <= r_d;
        end
    end

    // port decode
    logic [15:0] slot_off;

    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_wdata = '0;
        slot_off  = OFF_BASE_SLOT;
        unique case (r_q.state)
            S_W_BASE: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wdata = DATA_W'(r_q.base);
            end
            S_W_TRAP: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wdata = r_q.cur_trap;
                slot_off  = OFF_TRAP_SLOT;
            end
            S_W_IO: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                slot_off  = OFF_IO_SLOT;
            end
            S_W_HALT: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wdata = {{(DATA_W-1){1'b0}}, r_q.cur_halt};
                slot_off  = OFF_HALT_SLOT;
            end
            S_R_BASE: mem_valid = 1'b1;
            S_R_IO: begin
                mem_valid = 1'b1;
                slot_off  = OFF_IO_SLOT;
            end
            S_R_HALT: begin
                mem_valid = 1'b1;
                slot_off  = OFF_HALT_SLOT;
            end
            default: ;
        endcase
    end

    assign mem_addr    = r_q.base + ADDR_W'(slot_off);
    assign vec_req     = (r_q.state == S_VEC);
    assign entry_done  = (r_q.state == S_VEC);
    assign vec_addr    = r_q.base + ADDR_W'(OFF_VECTOR);
    assign resume_done = r_q.done;
    assign resume_act  = r_q.act;
    assign halt_err    = r_q.err;
    assign shutdown    = (r_q.state == S_SHUT);
    assign in_smm      = (r_q.state != S_IDLE) && (r_q.state != S_SHUT);

    // R6
    access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_wdata) && $stable(mem_write));

    // R5
    vector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> vec_addr[ALIGN_BITS-1:0] == '0);

    // R10
    shutdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> shutdown && !mem_valid && !resume_done);

    // R8
    halt_err_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_err |-> resume_done && resume_act == ACT_NEXT);

    // R12
    resume_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_done |-> !in_smm && !entry_done && !mem_valid);

endmodule

// File: tb/test_smm_seq.sv
module test_smm_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smi_req = 1'b0;
    logic        rsm_req = 1'b0;
    logic        cpu_halted = 1'b0;
    logic        trap_io_valid = 1'b0;
    logic [15:0] trap_io_addr = '0;
    logic        trap_io_read = 1'b0;
    logic        mem_valid, mem_write, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        vec_req, entry_done, resume_done, halt_err, in_smm, shutdown;
    logic [31:0] vec_addr;
    logic [1:0]  resume_act;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int hold_viol = 0;
    logic stall_en = 1'b0;
    logic tog = 1'b0;
    logic [31:0] cur_base = 32'h0003_0000;
    logic [31:0] seen_vec;
    logic [1:0]  seen_act;
    logic        seen_err;
    logic        prev_wait;
    logic [31:0] prev_addr, prev_wdata;

    logic [31:0] bmem [128];

    always #4 clk = ~clk;

    smm_seq i_smm_seq (
        .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .rsm_req(rsm_req),
        .cpu_halted(cpu_halted), .trap_io_valid(trap_io_valid),
        .trap_io_addr(trap_io_addr), .trap_io_read(trap_io_read),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .vec_req(vec_req), .vec_addr(vec_addr), .entry_done(entry_done),
        .resume_done(resume_done), .resume_act(resume_act), .halt_err(halt_err),
        .in_smm(in_smm), .shutdown(shutdown)
    );

    function automatic int widx(logic [31:0] a);
        return int'({a[18:15], a[4:2]});
    endfunction

    assign mem_ready = !stall_en || tog;
    assign mem_rdata = bmem[widx(mem_addr)];

    always @(posedge clk) begin
        tog <= ~tog;
        cycles <= cycles + 1;
        if (mem_valid && mem_ready && mem_write) bmem[widx(mem_addr)] <= mem_wdata;
    end

    // hold monitor for R6, sampled at the falling edge
    always @(negedge clk) begin
        if (prev_wait && (!mem_valid || mem_addr != prev_addr || mem_wdata != prev_wdata))
            hold_viol <= hold_viol + 1;
        prev_wait  <= mem_valid && !mem_ready;
        prev_addr  <= mem_addr;
        prev_wdata <= mem_wdata;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
                finish_run();
            end
        end
    end

    task automatic pulse_smi(logic halted, logic v, logic [15:0] a, logic rd);
        @(negedge clk);
        cpu_halted = halted; trap_io_valid = v; trap_io_addr = a; trap_io_read = rd;
        smi_req = 1'b1;
        @(negedge clk);
        smi_req = 1'b0;
    endtask

    task automatic wait_entry(string req);
        bit got = 0;
        for (int i = 0; i < 200 && !got; i++) begin
            @(negedge clk);
            if (entry_done) begin
                got = 1;
                seen_vec = vec_addr;
                check(req, {31'b0, vec_req}, 32'd1);
            end
        end
        check(req, {31'b0, got}, 32'd1);
    endtask

    task automatic do_rsm(string req);
        bit got = 0;
        @(negedge clk);
        rsm_req = 1'b1;
        @(negedge clk);
        rsm_req = 1'b0;
        for (int i = 0; i < 200 && !got; i++) begin
            if (resume_done) begin
                got = 1;
                seen_act = resume_act;
                seen_err = halt_err;
                check({req, " in_smm at done"}, {31'b0, in_smm}, 32'd0);
            end else begin
                @(negedge clk);
            end
        end
        check(req, {31'b0, got}, 32'd1);
    endtask

    function automatic logic [31:0] slot(logic [15:0] off);
        return bmem[widx(cur_base + {16'h0, off})];
    endfunction

    task automatic set_slot(logic [15:0] off, logic [31:0] v);
        bmem[widx(cur_base + {16'h0, off})] = v;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 in_smm", {31'b0, in_smm}, 32'd0);
        check("R1 mem_valid", {31'b0, mem_valid}, 32'd0);
        check("R1 shutdown", {31'b0, shutdown}, 32'd0);
        check("R1 vec_req", {31'b0, vec_req}, 32'd0);
    endtask

    task automatic t_entry_io_rerun();
        set_slot(16'h7F00, 32'hAA);
        set_slot(16'h7F04, 32'h55);
        pulse_smi(1'b0, 1'b1, 16'h1234, 1'b1);
        wait_entry("R5 entry");
        check("R1 R5 vector", seen_vec, 32'h0003_8000);
        check("R2 base slot", slot(16'h7EF8), 32'h0003_0000);
        check("R3 trap word read", slot(16'h7EFC), 32'h1234_0003);
        check("R4 io slot", slot(16'h7F00), 32'h0);
        check("R4 halt slot", slot(16'h7F04), 32'h0);
        @(negedge clk);
        check("R5 in_smm", {31'b0, in_smm}, 32'd1);
        set_slot(16'h7F00, 32'hFF);
        do_rsm("R7 resume");
        check("R7 act io", {30'b0, seen_act}, 32'd1);
        check("R7 no err", {31'b0, seen_err}, 32'd0);
    endtask

    task automatic t_invalid_trap();
        pulse_smi(1'b1, 1'b0, 16'hBEEF, 1'b1);
        wait_entry("R3 entry");
        check("R3 trap word invalid", slot(16'h7EFC), 32'h0);
        check("R4 halt slot set", slot(16'h7F04), 32'h1);
        set_slot(16'h7F00, 32'hFF);
        do_rsm("R7 priority");
        check("R7 io over halt", {30'b0, seen_act}, 32'd1);
        pulse_smi(1'b0, 1'b1, 16'h00C8, 1'b0);
        wait_entry("R3 entry write");
        check("R3 trap word write", slot(16'h7EFC), 32'h00C8_0002);
        do_rsm("R7 zero slot");
        check("R7 no rerun", {30'b0, seen_act}, 32'd0);
    endtask

    task automatic t_halt_rules();
        pulse_smi(1'b1, 1'b0, 16'h0, 1'b0);
        wait_entry("R8 entry a");
        do_rsm("R8 e1x1");
        check("R8 e1x1 act", {30'b0, seen_act}, 32'd2);
        check("R8 e1x1 err", {31'b0, seen_err}, 32'd0);
        pulse_smi(1'b1, 1'b0, 16'h0, 1'b0);
        wait_entry("R8 entry b");
        set_slot(16'h7F04, 32'h0);
        do_rsm("R8 e1x0");
        check("R8 e1x0 act", {30'b0, seen_act}, 32'd0);
        check("R8 e1x0 err", {31'b0, seen_err}, 32'd0);
        pulse_smi(1'b0, 1'b0, 16'h0, 1'b0);
        wait_entry("R8 entry c");
        set_slot(16'h7F04, 32'h1);
        do_rsm("R8 e0x1");
        check("R8 e0x1 act", {30'b0, seen_act}, 32'd0);
        check("R8 e0x1 err", {31'b0, seen_err}, 32'd1);
        @(negedge clk);
        check("R12 err one cycle", {31'b0, halt_err}, 32'd0);
    endtask

    task automatic t_relocate();
        pulse_smi(1'b0, 1'b0, 16'h0, 1'b0);
        wait_entry("R9 entry");
        set_slot(16'h7EF8, 32'h0005_0000);
        do_rsm("R9 resume");
        cur_base = 32'h0005_0000;
        pulse_smi(1'b0, 1'b1, 16'h0042, 1'b1);
        wait_entry("R9 entry new");
        check("R9 vector", seen_vec, 32'h0005_8000);
        check("R9 base slot", slot(16'h7EF8), 32'h0005_0000);
        check("R9 trap at new base", slot(16'h7EFC), 32'h0042_0003);
        do_rsm("R9 resume 2");
    endtask

    task automatic t_pending();
        pulse_smi(1'b0, 1'b1, 16'h1111, 1'b1);
        wait_entry("R11 first");
        pulse_smi(1'b0, 1'b1, 16'h0077, 1'b0);
        check("R11 first trap", slot(16'h7EFC), 32'h1111_0003);
        do_rsm("R11 resume");
        wait_entry("R11 second");
        check("R11 second trap", slot(16'h7EFC), 32'h0077_0002);
        do_rsm("R11 resume 2");
    endtask

    task automatic t_rsm_idle();
        int bad = 0;
        @(negedge clk);
        rsm_req = 1'b1;
        @(negedge clk);
        rsm_req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (mem_valid || resume_done || in_smm) bad++;
            @(negedge clk);
        end
        check("R12 rsm ignored", bad, 0);
    endtask

    task automatic t_stall();
        stall_en = 1'b1;
        hold_viol = 0;
        set_slot(16'h7F00, 32'h77);
        pulse_smi(1'b1, 1'b1, 16'h0300, 1'b1);
        wait_entry("R6 entry");
        check("R6 base slot", slot(16'h7EF8), cur_base);
        check("R6 trap", slot(16'h7EFC), 32'h0300_0003);
        check("R6 io", slot(16'h7F00), 32'h0);
        do_rsm("R6 resume");
        check("R6 halt act", {30'b0, seen_act}, 32'd2);
        check("R6 hold", hold_viol, 0);
        stall_en = 1'b0;
    endtask

    task automatic t_shutdown();
        int bad = 0;
        bit done_seen = 0;
        pulse_smi(1'b0, 1'b0, 16'h0, 1'b0);
        wait_entry("R10 entry");
        set_slot(16'h7EF8, 32'h0005_0004);
        @(negedge clk);
        rsm_req = 1'b1;
        @(negedge clk);
        rsm_req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (resume_done) done_seen = 1;
            @(negedge clk);
        end
        check("R10 shutdown", {31'b0, shutdown}, 32'd1);
        check("R10 no done", {31'b0, done_seen}, 32'd0);
        pulse_smi(1'b0, 1'b1, 16'h5, 1'b1);
        rsm_req = 1'b1;
        @(negedge clk);
        rsm_req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (mem_valid || entry_done || resume_done || !shutdown) bad++;
            @(negedge clk);
        end
        check("R10 sticky", bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) bmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_entry_io_rerun();
        t_invalid_trap();
        t_halt_rules();
        t_relocate();
        t_pending();
        t_rsm_idle();
        t_stall();
        t_shutdown();
        finish_run();
    end

endmodule